// File: doc/BRIEF.md
# DRAM Frequency-Change Command Sequencer

This block carries an attached DRAM through a change of its operating clock. A single start pulse launches a fixed ritual. The ritual reads back the live mode registers, takes the DRAM into self-refresh, has an external clock unit retune, and brings the DRAM back out. It then rewrites only those mode registers that disagree with the requested values, asks for the controller timing set to be reloaded, and finally resets the DLL if it is to remain enabled. Three memory families are handled, chosen by a type code sampled at start: DDR2, DDR3 and GDDR3.

Every action leaves on a single command port, one command at a time, and is held there until the responder acknowledges it. Mode-register reads return their data later with a valid strobe. Delays are written in nanoseconds as parameters. They are turned into clock cycles, rounded up, at elaboration and counted by an internal down-counter. The DRAM PHY, the clock generator and the contents of the timing set lie outside the block.

Top module: `dram_reclock_seq`

## Requirements
- R1: Type code 0 is DDR2, 1 is DDR3 and 2 is GDDR3. A start with code 3 raises `err_o` and `done_o` together for one cycle, leaves the block idle and issues no command.
- R2: The first commands are mode-register reads (op 7), in the order register 2, register 1, register 0. Register 2 is read only for DDR3; for other types its current value is taken to equal the target. Read data is captured on `rd_valid_i`.
- R3: The DLL-disable bit of mode register 1 is bit 0 for DDR2 and DDR3 and bit 6 for GDDR3. If that bit is clear in the read-back value but set in the target, the block issues a precharge (op 0). It then writes register 1 (op 6) with the read-back value plus that bit, and waits the mode-register delay. In every other case, none of these three steps happens.
- R4: Self-refresh entry issues, in this order: precharge (0), refresh (1), refresh (1), auto-refresh off (2), self-refresh on (4), the entry wait, and a clock-change request (op 8).
- R5: Self-refresh exit issues, in this order: the exit wait, precharge (0), self-refresh off (5), auto-refresh on (3), and the exit-to-valid wait.
- R6: Mode registers 2, 1 and 0 are then written in that order, each only when its read-back value differs from its target, with the target value as data. A timing-update request (op 9) follows.
- R7: When the target keeps the DLL enabled, register 0 is written with bit 8 set, then again with bit 8 clear. Each write is followed by the mode-register delay, and the lock wait follows the second one. GDDR3 alone then adds a final precharge. Non-write commands carry register index 0 and data 0.
- R8: Every mode-register write is followed by the mode-register delay, 1000 ns by default. The DLL lock wait is 2000, 12000 or 40000 ns for DDR2, DDR3 or GDDR3. A delay of T ns holds off the next command for at least ceil(T*1000/CLK_PS) cycles, and a zero delay adds no countdown.
- R9: A command stays on the port, unchanged, until `cmd_ack_i` is seen.
- R10: `done_o` pulses for one cycle when the sequence ends. A start that arrives while `busy_o` is high has no effect, even one carrying type code 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| mem_type_i | input | 2 | Memory family code, sampled at start |
| tgt_mr0_i | input | MR_W | Target mode register 0 |
| tgt_mr1_i | input | MR_W | Target mode register 1 |
| tgt_mr2_i | input | MR_W | Target mode register 2 |
| cmd_valid_o | output | 1 | Command present |
| cmd_op_o | output | 4 | Command opcode |
| cmd_mr_o | output | 2 | Mode register index |
| cmd_data_o | output | MR_W | Mode register write data |
| cmd_ack_i | input | 1 | Command accepted |
| rd_data_i | input | MR_W | Mode register read data |
| rd_valid_i | input | 1 | Read data strobe |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished (one cycle) |
| err_o | output | 1 | Unsupported type (one cycle) |

## Verification
The bench sweeps all three memory families against all four combinations of DLL state before and after. Across these runs it varies which mode registers already match, so that conditional writes appear and vanish. Each sweep exposes a distinct failure. A wrong DLL-bit position for GDDR3 would trigger or skip the DLL-off entry. A missing register-2 read guard would emit a spurious read on DDR2. Dropping the equality test would produce extra writes, and a wrong bit 8 value would corrupt the DLL reset pair. The mode-register delay is set to 1001 ns so that truncating instead of rounding up shortens a measured gap below its bound. A busy-time start with the error type code shows whether the block aborts mid-sequence.

// File: rtl/dram_reclock_pkg.sv
package dram_reclock_pkg;

   typedef enum logic [3:0] {
      OP_PRECHARGE  = 4'd0,
      OP_REFRESH    = 4'd1,
      OP_AREF_OFF   = 4'd2,
      OP_AREF_ON    = 4'd3,
      OP_SELF_ON    = 4'd4,
      OP_SELF_OFF   = 4'd5,
      OP_MR_WRITE   = 4'd6,
      OP_MR_READ    = 4'd7,
      OP_CLK_CHANGE = 4'd8,
      OP_TIMING_UPD = 4'd9
   } cmd_op_e;

   typedef enum logic [1:0] {
      MT_DDR2  = 2'd0,
      MT_DDR3  = 2'd1,
      MT_GDDR3 = 2'd2,
      MT_BAD   = 2'd3
   } mem_type_e;

   typedef enum logic [2:0] {
      SK_SKIP, SK_CMD, SK_READ, SK_WAIT, SK_END
   } step_kind_e;

   function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned clk_ps);
      return (ns * 1000 + clk_ps - 1) / clk_ps;
   endfunction

   function automatic int unsigned max_u(int unsigned a, int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dram_reclock_timer.sv
module dram_reclock_timer #(
   parameter int unsigned CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [CW-1:0] val_i,
   output logic          last_o
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load_i)         cnt_q <= val_i;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign last_o = (cnt_q == CW'(1));

   AST_TMR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (cnt_q == $past(val_i)));                                  // R8

   AST_TMR_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));         // R8

endmodule

// File: rtl/dram_reclock_steps.sv
module dram_reclock_steps
   import dram_reclock_pkg::*;
#(
   parameter int unsigned MR_W        = 16,
   parameter int unsigned CW          = 8,
   parameter int unsigned MRS_CYC     = 1,
   parameter int unsigned SRE_CYC     = 0,
   parameter int unsigned SRX_CYC     = 0,
   parameter int unsigned XS_CYC      = 0,
   parameter int unsigned DLLK2_CYC   = 1,
   parameter int unsigned DLLK3_CYC   = 1,
   parameter int unsigned DLLKG_CYC   = 1,
   parameter int unsigned DLL_BIT_STD = 0,
   parameter int unsigned DLL_BIT_G   = 6,
   parameter int unsigned DLL_RST_BIT = 8
) (
   input  logic [4:0]            pc_i,
   input  mem_type_e             mtype_i,
   input  logic [2:0][MR_W-1:0]  cur_i,
   input  logic [2:0][MR_W-1:0]  tgt_i,
   output step_kind_e            kind_o,
   output cmd_op_e               op_o,
   output logic [1:0]            mr_o,
   output logic [MR_W-1:0]       data_o,
   output logic [CW-1:0]         wait_o
);

   localparam logic [MR_W-1:0] RST_MASK = MR_W'(1) << DLL_RST_BIT;

   logic [MR_W-1:0] dll_mask;
   logic            tgt_off, cur_off, enter_off;

   always_comb begin
      dll_mask  = (mtype_i == MT_GDDR3) ? (MR_W'(1) << DLL_BIT_G) : (MR_W'(1) << DLL_BIT_STD);
      tgt_off   = |(tgt_i[1] & dll_mask);
      cur_off   = |(cur_i[1] & dll_mask);
      enter_off = !cur_off && tgt_off;
   end

   always_comb begin
      kind_o = SK_SKIP;
      op_o   = OP_PRECHARGE;
      mr_o   = 2'd0;
      data_o = '0;
      wait_o = '0;
      case (pc_i)
         5'd0:  if (mtype_i == MT_DDR3) begin kind_o = SK_READ; op_o = OP_MR_READ; mr_o = 2'd2; end
         5'd1:  begin kind_o = SK_READ; op_o = OP_MR_READ; mr_o = 2'd1; end
         5'd2:  begin kind_o = SK_READ; op_o = OP_MR_READ; mr_o = 2'd0; end
         5'd3:  if (enter_off) kind_o = SK_CMD;
         5'd4:  if (enter_off) begin
                   kind_o = SK_CMD; op_o = OP_MR_WRITE; mr_o = 2'd1;
                   data_o = cur_i[1] | dll_mask;
                end
         5'd5:  if (enter_off) begin kind_o = SK_WAIT; wait_o = CW'(MRS_CYC); end
         5'd6:  kind_o = SK_CMD;
         5'd7:  begin kind_o = SK_CMD; op_o = OP_REFRESH; end
         5'd8:  begin kind_o = SK_CMD; op_o = OP_REFRESH; end
         5'd9:  begin kind_o = SK_CMD; op_o = OP_AREF_OFF; end
         5'd10: begin kind_o = SK_CMD; op_o = OP_SELF_ON; end
         5'd11: begin kind_o = SK_WAIT; wait_o = CW'(SRE_CYC); end
         5'd12: begin kind_o = SK_CMD; op_o = OP_CLK_CHANGE; end
         5'd13: begin kind_o = SK_WAIT; wait_o = CW'(SRX_CYC); end
         5'd14: kind_o = SK_CMD;
         5'd15: begin kind_o = SK_CMD; op_o = OP_SELF_OFF; end
         5'd16: begin kind_o = SK_CMD; op_o = OP_AREF_ON; end
         5'd17: begin kind_o = SK_WAIT; wait_o = CW'(XS_CYC); end
         5'd18, 5'd20, 5'd22: begin
                   mr_o = (pc_i == 5'd18) ? 2'd2 : (pc_i == 5'd20) ? 2'd1 : 2'd0;
                   if (cur_i[mr_o] != tgt_i[mr_o]) begin
                      kind_o = SK_CMD; op_o = OP_MR_WRITE; data_o = tgt_i[mr_o];
                   end else begin
                      mr_o = 2'd0;
                   end
                end
         5'd19: if (cur_i[2] != tgt_i[2]) begin kind_o = SK_WAIT; wait_o = CW'(MRS_CYC); end
         5'd21: if (cur_i[1] != tgt_i[1]) begin kind_o = SK_WAIT; wait_o = CW'(MRS_CYC); end
         5'd23: if (cur_i[0] != tgt_i[0]) begin kind_o = SK_WAIT; wait_o = CW'(MRS_CYC); end
         5'd24: begin kind_o = SK_CMD; op_o = OP_TIMING_UPD; end
         5'd25: if (!tgt_off) begin
                   kind_o = SK_CMD; op_o = OP_MR_WRITE; data_o = tgt_i[0] | RST_MASK;
                end
         5'd26, 5'd28: if (!tgt_off) begin kind_o = SK_WAIT; wait_o = CW'(MRS_CYC); end
         5'd27: if (!tgt_off) begin
                   kind_o = SK_CMD; op_o = OP_MR_WRITE; data_o = tgt_i[0] & ~RST_MASK;
                end
         5'd29: if (!tgt_off) begin
                   kind_o = SK_WAIT;
                   wait_o = (mtype_i == MT_GDDR3) ? CW'(DLLKG_CYC) :
                            (mtype_i == MT_DDR3)  ? CW'(DLLK3_CYC) : CW'(DLLK2_CYC);
                end
         5'd30: if (!tgt_off && mtype_i == MT_GDDR3) kind_o = SK_CMD;
         default: kind_o = SK_END;
      endcase
   end

endmodule

// File: rtl/dram_reclock_seq.sv
module dram_reclock_seq
   import dram_reclock_pkg::*;
#(
   parameter int unsigned MR_W           = 16,
   parameter int unsigned CLK_PS         = 5000,
   parameter int unsigned T_MRS_NS       = 1000,
   parameter int unsigned T_SRE_NS       = 0,
   parameter int unsigned T_SRX_NS       = 0,
   parameter int unsigned T_XS_NS        = 0,
   parameter int unsigned T_DLLK_DDR2_NS = 2000,
   parameter int unsigned T_DLLK_DDR3_NS = 12000,
   parameter int unsigned T_DLLK_GD_NS   = 40000,
   parameter int unsigned DLL_BIT_STD    = 0,
   parameter int unsigned DLL_BIT_GDDR3  = 6,
   parameter int unsigned DLL_RST_BIT    = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic [1:0]      mem_type_i,
   input  logic [MR_W-1:0] tgt_mr0_i,
   input  logic [MR_W-1:0] tgt_mr1_i,
   input  logic [MR_W-1:0] tgt_mr2_i,
   output logic            cmd_valid_o,
   output logic [3:0]      cmd_op_o,
   output logic [1:0]      cmd_mr_o,
   output logic [MR_W-1:0] cmd_data_o,
   input  logic            cmd_ack_i,
   input  logic [MR_W-1:0] rd_data_i,
   input  logic            rd_valid_i,
   output logic            busy_o,
   output logic            done_o,
   output logic            err_o
);

   localparam int unsigned MRS_CYC   = ns_to_cyc(T_MRS_NS, CLK_PS);
   localparam int unsigned SRE_CYC   = ns_to_cyc(T_SRE_NS, CLK_PS);
   localparam int unsigned SRX_CYC   = ns_to_cyc(T_SRX_NS, CLK_PS);
   localparam int unsigned XS_CYC    = ns_to_cyc(T_XS_NS, CLK_PS);
   localparam int unsigned DLLK2_CYC = ns_to_cyc(T_DLLK_DDR2_NS, CLK_PS);
   localparam int unsigned DLLK3_CYC = ns_to_cyc(T_DLLK_DDR3_NS, CLK_PS);
   localparam int unsigned DLLKG_CYC = ns_to_cyc(T_DLLK_GD_NS, CLK_PS);
   localparam int unsigned MAX_CYC   = max_u(max_u(max_u(MRS_CYC, SRE_CYC), max_u(SRX_CYC, XS_CYC)),
                                             max_u(max_u(DLLK2_CYC, DLLK3_CYC), DLLKG_CYC));
   localparam int unsigned CW        = $clog2(MAX_CYC + 1) + 1;

   if (CLK_PS == 0) begin : g_bad_clk
      $error("CLK_PS must be non-zero");
   end
   if (MR_W <= DLL_RST_BIT || MR_W <= DLL_BIT_GDDR3 || MR_W <= DLL_BIT_STD) begin : g_bad_width
      $error("MR_W too narrow for the DLL bit positions");
   end

   typedef enum logic [2:0] {ST_IDLE, ST_DISP, ST_CMD, ST_RDATA, ST_WAIT} state_e;

   state_e               state_q;
   logic [4:0]           pc_q;
   mem_type_e            mtype_q;
   logic [2:0][MR_W-1:0] tgt_q, cur_q;
   logic                 done_q, err_q;

   step_kind_e           step_kind;
   cmd_op_e              step_op;
   logic [1:0]           step_mr;
   logic [MR_W-1:0]      step_data;
   logic [CW-1:0]        step_wait;
   logic                 tmr_load, tmr_last;
   logic                 bad_type;

   dram_reclock_steps #(
      .MR_W(MR_W), .CW(CW), .MRS_CYC(MRS_CYC), .SRE_CYC(SRE_CYC), .SRX_CYC(SRX_CYC),
      .XS_CYC(XS_CYC), .DLLK2_CYC(DLLK2_CYC), .DLLK3_CYC(DLLK3_CYC), .DLLKG_CYC(DLLKG_CYC),
      .DLL_BIT_STD(DLL_BIT_STD), .DLL_BIT_G(DLL_BIT_GDDR3), .DLL_RST_BIT(DLL_RST_BIT)
   ) u_steps (
      .pc_i(pc_q), .mtype_i(mtype_q), .cur_i(cur_q), .tgt_i(tgt_q),
      .kind_o(step_kind), .op_o(step_op), .mr_o(step_mr), .data_o(step_data), .wait_o(step_wait)
   );

   assign tmr_load = (state_q == ST_DISP) && (step_kind == SK_WAIT) && (step_wait != '0);

   dram_reclock_timer #(.CW(CW)) u_timer (
      .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .val_i(step_wait), .last_o(tmr_last)
   );

   assign bad_type = (mem_type_i == MT_BAD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pc_q    <= '0;
         mtype_q <= MT_DDR2;
         tgt_q   <= '0;
         cur_q   <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         case (state_q)
            ST_IDLE: if (start_i) begin
               if (bad_type) begin
                  done_q <= 1'b1;
                  err_q  <= 1'b1;
               end else begin
                  state_q <= ST_DISP;
                  pc_q    <= '0;
                  mtype_q <= mem_type_e'(mem_type_i);
                  tgt_q   <= {tgt_mr2_i, tgt_mr1_i, tgt_mr0_i};
                  cur_q   <= {tgt_mr2_i, {MR_W{1'b0}}, {MR_W{1'b0}}};
               end
            end
            ST_DISP: begin
               case (step_kind)
                  SK_END:  begin done_q <= 1'b1; state_q <= ST_IDLE; end
                  SK_SKIP: pc_q <= pc_q + 1'b1;
                  SK_WAIT: if (step_wait == '0) pc_q <= pc_q + 1'b1;
                           else state_q <= ST_WAIT;
                  default: state_q <= ST_CMD;
               endcase
            end
            ST_CMD: if (cmd_ack_i) begin
               if (step_kind == SK_READ) state_q <= ST_RDATA;
               else begin pc_q <= pc_q + 1'b1; state_q <= ST_DISP; end
            end
            ST_RDATA: if (rd_valid_i) begin
               cur_q[step_mr] <= rd_data_i;
               pc_q    <= pc_q + 1'b1;
               state_q <= ST_DISP;
            end
            ST_WAIT: if (tmr_last) begin
               pc_q    <= pc_q + 1'b1;
               state_q <= ST_DISP;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign cmd_valid_o = (state_q == ST_CMD);
   assign cmd_op_o    = step_op;
   assign cmd_mr_o    = step_mr;
   assign cmd_data_o  = step_data;
   assign busy_o      = (state_q != ST_IDLE);
   assign done_o      = done_q;
   assign err_o       = err_q;

   AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_o && !cmd_ack_i) |=> (cmd_valid_o && $stable(cmd_op_o) &&
                                       $stable(cmd_mr_o) && $stable(cmd_data_o)));   // R9

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);                                                       // R10

   AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i));                                         // R10

   AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (done_o && !cmd_valid_o && !busy_o));                            // R1

   AST_BAD_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i && mem_type_i == 2'd3) |=> (err_o && !busy_o));       // R1

endmodule

// File: tb/tb_dram_reclock_seq.sv
module tb_dram_reclock_seq;

   localparam int MR_W   = 16;
   localparam int MRS_NS = 1001;
   localparam int MRS_C  = (MRS_NS * 1000 + 4999) / 5000;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [1:0]      mtype = 2'd0;
   logic [MR_W-1:0] tg0 = '0, tg1 = '0, tg2 = '0;
   logic            cmd_valid, cmd_ack = 1'b0, rd_valid = 1'b0;
   logic [3:0]      cmd_op;
   logic [1:0]      cmd_mr;
   logic [MR_W-1:0] cmd_data, rd_data = '0;
   logic            busy, done, err;

   always #2.5 clk = ~clk;

   dram_reclock_seq #(.MR_W(MR_W), .CLK_PS(5000), .T_MRS_NS(MRS_NS)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .mem_type_i(mtype),
      .tgt_mr0_i(tg0), .tgt_mr1_i(tg1), .tgt_mr2_i(tg2),
      .cmd_valid_o(cmd_valid), .cmd_op_o(cmd_op), .cmd_mr_o(cmd_mr), .cmd_data_o(cmd_data),
      .cmd_ack_i(cmd_ack), .rd_data_i(rd_data), .rd_valid_i(rd_valid),
      .busy_o(busy), .done_o(done), .err_o(err)
   );

   int nchk = 0, nerr = 0, cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(bit ok, string req, string what, int act, int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
   endtask

   // responder and command log
   int nlog = 0;
   int l_op[64], l_mr[64], l_data[64], l_first[64], l_rel[64];
   bit l_hold[64];
   logic [MR_W-1:0] m_cur [3];

   initial begin
      int n;
      forever begin
         @(negedge clk);
         if (cmd_valid && nlog < 64) begin
            n = nlog;
            l_first[n] = cyc; l_op[n] = int'(cmd_op); l_mr[n] = int'(cmd_mr);
            l_data[n] = int'(cmd_data); l_hold[n] = 1'b1;
            for (int k = 0; k < n % 3; k++) begin
               @(negedge clk);
               if (!cmd_valid || int'(cmd_op) != l_op[n] || int'(cmd_mr) != l_mr[n] ||
                   int'(cmd_data) != l_data[n]) l_hold[n] = 1'b0;
            end
            cmd_ack = 1'b1; l_rel[n] = cyc;
            @(negedge clk);
            cmd_ack = 1'b0;
            if (l_op[n] == 7) begin
               rd_valid = 1'b1; rd_data = m_cur[l_mr[n]]; l_rel[n] = cyc;
               @(negedge clk);
               rd_valid = 1'b0;
            end
            nlog = n + 1;
         end
      end
   end

   // expected model
   int    ne, g;
   int    e_op[64], e_mr[64], e_data[64], e_gap[64];
   string e_tag[64];

   task automatic push(int op, int mr, int data, string tag);
      e_op[ne] = op; e_mr[ne] = mr; e_data[ne] = data; e_tag[ne] = tag; e_gap[ne] = g;
      ne++; g = 2;
   endtask

   task automatic wt(int n);
      if (n > 0) g += n + 1;
   endtask

   task automatic build(int t);
      logic [MR_W-1:0] mask, c2e;
      int dllk;
      mask = (t == 2) ? 16'h0040 : 16'h0001;
      c2e  = (t == 1) ? m_cur[2] : tg2;
      dllk = (t == 0) ? 400 : (t == 1) ? 2400 : 8000;
      ne = 0; g = 2;
      if (t == 1) push(7, 2, 0, "R2");
      push(7, 1, 0, "R2");
      push(7, 0, 0, "R2");
      if ((m_cur[1] & mask) == 0 && (tg1 & mask) != 0) begin
         push(0, 0, 0, "R3"); push(6, 1, int'(m_cur[1] | mask), "R3"); wt(MRS_C);
      end
      push(0, 0, 0, "R4"); push(1, 0, 0, "R4"); push(1, 0, 0, "R4");
      push(2, 0, 0, "R4"); push(4, 0, 0, "R4"); push(8, 0, 0, "R4");
      push(0, 0, 0, "R5"); push(5, 0, 0, "R5"); push(3, 0, 0, "R5");
      if (c2e != tg2)      begin push(6, 2, int'(tg2), "R6"); wt(MRS_C); end
      if (m_cur[1] != tg1) begin push(6, 1, int'(tg1), "R6"); wt(MRS_C); end
      if (m_cur[0] != tg0) begin push(6, 0, int'(tg0), "R6"); wt(MRS_C); end
      push(9, 0, 0, "R6");
      if ((tg1 & mask) == 0) begin
         push(6, 0, int'(tg0 | 16'h0100), "R7"); wt(MRS_C);
         push(6, 0, int'(tg0 & ~16'h0100), "R7"); wt(MRS_C); wt(dllk);
         if (t == 2) push(0, 0, 0, "R7");
      end
   endtask

   task automatic run(int t, int s);
      logic [MR_W-1:0] mask;
      int to;
      bit err_seen;
      mask = (t == 2) ? 16'h0040 : 16'h0001;
      m_cur[0] = 16'h0a30 + 16'(t * 16 + s);
      tg0      = (s == 2) ? m_cur[0] : (m_cur[0] ^ 16'h0114);
      m_cur[1] = 16'h0100 | 16'(s << 2) | ((s & 1) != 0 ? mask : 16'h0);
      tg1      = (t == 1 && s == 1) ? m_cur[1] : (16'h0180 | ((s & 2) != 0 ? mask : 16'h0));
      m_cur[2] = 16'h0008 + 16'(t);
      tg2      = m_cur[2] + 16'(s & 1);
      build(t);
      nlog = 0; err_seen = 1'b0; to = 0;
      mtype = 2'(t);
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      if (t == 0 && s == 0) begin
         repeat (30) @(negedge clk);
         mtype = 2'd3; start = 1'b1;
         @(negedge clk); start = 1'b0; mtype = 2'(t);
         if (err) err_seen = 1'b1;
      end
      while (!done && to < 20000) begin
         @(negedge clk); to++;
         if (err) err_seen = 1'b1;
      end
      chk(done, "R10", "done pulse seen", int'(done), 1);
      chk(!err_seen, "R10", "no error during run (busy start ignored)", int'(err_seen), 0);
      @(negedge clk);
      chk(!done && !busy, "R10", "done one cycle then idle", int'(done) | (int'(busy) << 1), 0);
      chk(nlog == ne, e_tag[0], "command count R2 R3 R4 R5 R6 R7", nlog, ne);
      for (int i = 0; i < ne && i < nlog; i++) begin
         chk(l_op[i] == e_op[i], e_tag[i], $sformatf("op of cmd %0d", i), l_op[i], e_op[i]);
         chk(l_mr[i] == e_mr[i], e_tag[i], $sformatf("mr of cmd %0d", i), l_mr[i], e_mr[i]);
         chk(l_data[i] == e_data[i], e_tag[i], $sformatf("data of cmd %0d", i), l_data[i], e_data[i]);
         chk(l_hold[i], "R9", $sformatf("hold of cmd %0d", i), int'(l_hold[i]), 1);
         if (i > 0) begin
            chk(l_first[i] - l_rel[i-1] >= e_gap[i] && l_first[i] - l_rel[i-1] <= e_gap[i] + 12,
                "R8", $sformatf("gap before cmd %0d", i), l_first[i] - l_rel[i-1], e_gap[i]);
         end
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      nchk++; nerr++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !cmd_valid && !done && !err, "R10", "reset state",
          {28'd0, busy, cmd_valid, done, err}, 0);
      // R1: unsupported type aborts with no command
      nlog = 0; mtype = 2'd3;
      start = 1'b1; @(negedge clk); start = 1'b0;
      chk(err && done, "R1", "error and done on bad type", {30'd0, err, done}, 3);
      chk(!busy, "R1", "idle after bad type", int'(busy), 0);
      repeat (6) @(negedge clk);
      chk(nlog == 0, "R1", "no command on bad type", nlog, 0);
      for (int t = 0; t < 3; t++)
         for (int s = 0; s < 4; s++)
            run(t, s);
      summary();
      $finish;
   end

endmodule